// File: doc/BRIEF.md
# IDE Task-File Window Bridge

This block sits between a host register bus and an IDE core. The host sees a 4 KB memory window. Inside it, the IDE registers sit at a spacing of 16 bytes. Each host request is decoded into a register index, which is the window offset divided by sixteen. The request goes to the core's register bus only when the index and the access size together name a real register.

Byte accesses reach the seven task-file registers and the control/alternate-status register. The control/alternate-status register can be reached at two different indices. Halfword and word accesses reach only the data port. The host bus is big-endian and the device is little-endian, so the bridge swaps the byte order of data-port values in both directions. A word access is split into two consecutive 16-bit beats on the core bus. Any read that hits no register still returns a response, filled with all ones to the width of the access.

Top module: `ide_mmio_bridge`

## Requirements
- R1: The register index is `req_addr[11:4]`. Address bits 3:0 and all bits above bit 11 have no effect on decoding.
- R2: A byte access at index 1 to 7 strobes `ide_sel` in the same cycle, with `ide_reg` equal to the index. A write drives `ide_wdata = {8'h00, req_wdata[7:0]}`. A read returns `{24'h0, ide_rdata[7:0]}`.
- R3: A byte access at index 8 or index 22 strobes the core with `ide_reg = 8` (control on write, alternate status on read). Its write data and read data are formed as in R2.
- R4: A byte access at any other index, including index 0, leaves `ide_sel` low. A byte read there returns `32'h0000_00FF`.
- R5: A halfword access (`req_size = 1`) at index 0 strobes `ide_reg = 0` and swaps bytes. A write drives `{w[7:0], w[15:8]}`. A read returns `{16'h0, r[7:0], r[15:8]}`.
- R6: A word access (`req_size = 2`) at index 0 produces two data beats in consecutive cycles, with `ide_reg = 0` on both. `host_ready` is low during the second beat. For a write, beat 0 carries `{w[23:16], w[31:24]}` and beat 1 carries `{w[7:0], w[15:8]}`.
- R7: For a word read, call the beat-0 data d0 and the beat-1 data d1. The read returns `{d0[7:0], d0[15:8], d1[7:0], d1[15:8]}`.
- R8: A halfword or word access at a nonzero index leaves `ide_sel` low. A read there returns `32'h0000_FFFF` for a halfword and `32'hFFFF_FFFF` for a word.
- R9: Each read gives exactly one `rsp_valid` pulse. The pulse comes one cycle after the read's last core beat, or one cycle after the request when no core beat is made. Writes produce no response.
- R10: While reset is held and after it is released, `rsp_valid` and `ide_sel` are low and `host_ready` is high.
- R11: `req_size = 3` is reserved. Such a request never strobes the core, and a read of it returns `32'hFFFF_FFFF`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_addr | input | ADDR_W | Host byte address |
| req_wdata | input | 32 | Host write data, right-aligned |
| host_ready | output | 1 | Low while the second beat of a word access is on the core bus |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 32 | Read data toward the host |
| ide_sel | output | 1 | Core register strobe |
| ide_wr | output | 1 | Core write enable |
| ide_reg | output | 4 | Core register number (0 data, 1-7 task file, 8 control/alt status) |
| ide_wdata | output | 16 | Core write data |
| ide_rdata | input | 16 | Core read data, valid in the strobe cycle |

## Verification
The assertions assume two things about the inputs. First, the host never raises `req_valid` while `host_ready` is low. Second, the core presents `ide_rdata` combinationally in the cycle it is strobed. The bench respects the first assumption by having the driver hold off for one extra cycle after every word access to the data port. It respects the second with a core model whose read data depends only on `ide_reg` and on a beat counter that advances at the clock edge. With these assumptions in place, each read, mapped or not, can be tied to one response exactly one or two cycles later.

// File: rtl/ide_bridge_pkg.sv
package ide_bridge_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_TASK = 2'd1,
    TGT_CTRL = 2'd2,
    TGT_DATA = 2'd3
  } target_e;

  localparam int unsigned CORE_REG_W = 4;
  localparam logic [CORE_REG_W-1:0] CTRL_CORE_REG = 4'd8;
  localparam logic [CORE_REG_W-1:0] DATA_CORE_REG = 4'd0;

  function automatic logic [15:0] swap16(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction

  function automatic logic [31:0] swap32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  // all-ones pattern as wide as the access
  function automatic logic [31:0] fill_ones(input acc_size_e sz);
    case (sz)
      SZ_BYTE: return 32'h0000_00FF;
      SZ_HALF: return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/ide_addr_decode.sv
module ide_addr_decode
  import ide_bridge_pkg::*;
#(
  parameter int unsigned WIN_BITS    = 12,
  parameter int unsigned STRIDE_BITS = 4,
  parameter int unsigned TASK_FIRST  = 1,
  parameter int unsigned TASK_LAST   = 7,
  parameter int unsigned CTRL_IDX_A  = 8,
  parameter int unsigned CTRL_IDX_B  = 22,
  localparam int unsigned IDX_W      = WIN_BITS - STRIDE_BITS
) (
  input  logic [WIN_BITS-1:0]   win_addr,
  input  acc_size_e             size,
  output logic [IDX_W-1:0]      reg_idx,
  output target_e               target,
  output logic [CORE_REG_W-1:0] core_reg
);

  always_comb begin
    reg_idx  = win_addr[WIN_BITS-1:STRIDE_BITS];
    target   = TGT_NONE;
    core_reg = DATA_CORE_REG;
    case (size)
      SZ_BYTE: begin
        if (int'(reg_idx) >= int'(TASK_FIRST) && int'(reg_idx) <= int'(TASK_LAST)) begin
          target   = TGT_TASK;
          core_reg = CORE_REG_W'(reg_idx);
        end else if (reg_idx == IDX_W'(CTRL_IDX_A) || reg_idx == IDX_W'(CTRL_IDX_B)) begin
          target   = TGT_CTRL;
          core_reg = CTRL_CORE_REG;
        end
      end
      SZ_HALF, SZ_WORD: begin
        if (reg_idx == '0) target = TGT_DATA;
      end
      default: target = TGT_NONE;
    endcase
  end

endmodule

// File: rtl/ide_beat_seq.sv
module ide_beat_seq
  import ide_bridge_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  accept,
  input  logic                  is_write,
  input  acc_size_e             size,
  input  target_e               target,
  input  logic [CORE_REG_W-1:0] core_reg,
  input  logic [31:0]           wdata,
  output logic                  ide_sel,
  output logic                  ide_wr,
  output logic [CORE_REG_W-1:0] ide_reg,
  output logic [15:0]           ide_wdata,
  output logic                  host_ready,
  output logic                  second_beat,
  output logic                  two_beat_start,
  output logic                  rd_final
);

  logic        pend_q;
  logic        pend_wr_q;
  logic [15:0] pend_wdata_q;
  logic [31:0] w_sw32;

  assign w_sw32         = swap32(wdata);
  assign second_beat    = pend_q;
  assign host_ready     = !pend_q;
  assign two_beat_start = accept && target == TGT_DATA && size == SZ_WORD;
  // a read is finished on its last beat, or at once if it makes no beat
  assign rd_final = (pend_q && !pend_wr_q) || (accept && !is_write && !two_beat_start);

  always_comb begin
    ide_sel   = 1'b0;
    ide_wr    = 1'b0;
    ide_reg   = DATA_CORE_REG;
    ide_wdata = '0;
    if (pend_q) begin
      ide_sel   = 1'b1;
      ide_wr    = pend_wr_q;
      ide_wdata = pend_wdata_q;
    end else if (accept && target != TGT_NONE) begin
      ide_sel = 1'b1;
      ide_wr  = is_write;
      ide_reg = core_reg;
      if (target == TGT_DATA)
        ide_wdata = (size == SZ_WORD) ? w_sw32[15:0] : swap16(wdata[15:0]);
      else
        ide_wdata = {8'h00, wdata[7:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q       <= 1'b0;
      pend_wr_q    <= 1'b0;
      pend_wdata_q <= '0;
    end else begin
      pend_q <= two_beat_start;
      if (two_beat_start) begin
        pend_wr_q    <= is_write;
        pend_wdata_q <= w_sw32[31:16];
      end
    end
  end

  // R6: the second beat never stretches beyond one cycle
  a_r6_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !host_ready |=> host_ready);

  // R6: a word data access is followed by a data-port beat
  a_r6_second_beat: assert property (@(posedge clk) disable iff (!rst_n)
    two_beat_start |=> ide_sel && ide_reg == DATA_CORE_REG && !host_ready);

endmodule

// File: rtl/ide_rsp_path.sv
module ide_rsp_path
  import ide_bridge_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        is_write,
  input  acc_size_e   size,
  input  target_e     target,
  input  logic        second_beat,
  input  logic        two_beat_start,
  input  logic        rd_final,
  input  logic [15:0] ide_rdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata
);

  logic [15:0] lo_q;
  logic [31:0] rsp_next;

  always_comb begin
    if (second_beat) begin
      rsp_next = swap32({ide_rdata, lo_q});
    end else begin
      case (target)
        TGT_NONE: rsp_next = fill_ones(size);
        TGT_DATA: rsp_next = {16'h0000, swap16(ide_rdata)};
        default:  rsp_next = {24'h0, ide_rdata[7:0]};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      lo_q      <= '0;
    end else begin
      rsp_valid <= rd_final;
      if (rd_final) rsp_rdata <= rsp_next;
      if (two_beat_start && !is_write) lo_q <= ide_rdata;
    end
  end

endmodule

// File: rtl/ide_mmio_bridge.sv
module ide_mmio_bridge
  import ide_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned WIN_BITS    = 12,
  parameter int unsigned STRIDE_BITS = 4,
  parameter int unsigned CTRL_IDX_A  = 8,
  parameter int unsigned CTRL_IDX_B  = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              host_ready,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              ide_sel,
  output logic              ide_wr,
  output logic [3:0]        ide_reg,
  output logic [15:0]       ide_wdata,
  input  logic [15:0]       ide_rdata
);

  localparam int unsigned IDX_W = WIN_BITS - STRIDE_BITS;

  acc_size_e             size;
  target_e               target;
  logic [IDX_W-1:0]      reg_idx;
  logic [CORE_REG_W-1:0] core_reg;
  logic                  accept;
  logic                  second_beat;
  logic                  two_beat_start;
  logic                  rd_final;
  logic                  addr_hi_unused;

  assign size           = acc_size_e'(req_size);
  assign accept         = req_valid && host_ready;
  assign addr_hi_unused = ^req_addr[ADDR_W-1:WIN_BITS];

  ide_addr_decode #(
    .WIN_BITS(WIN_BITS), .STRIDE_BITS(STRIDE_BITS),
    .TASK_FIRST(1), .TASK_LAST(7),
    .CTRL_IDX_A(CTRL_IDX_A), .CTRL_IDX_B(CTRL_IDX_B)
  ) u_dec (
    .win_addr(req_addr[WIN_BITS-1:0]),
    .size    (size),
    .reg_idx (reg_idx),
    .target  (target),
    .core_reg(core_reg)
  );

  ide_beat_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .accept        (accept),
    .is_write      (req_write),
    .size          (size),
    .target        (target),
    .core_reg      (core_reg),
    .wdata         (req_wdata),
    .ide_sel       (ide_sel),
    .ide_wr        (ide_wr),
    .ide_reg       (ide_reg),
    .ide_wdata     (ide_wdata),
    .host_ready    (host_ready),
    .second_beat   (second_beat),
    .two_beat_start(two_beat_start),
    .rd_final      (rd_final)
  );

  ide_rsp_path u_rsp (
    .clk           (clk),
    .rst_n         (rst_n),
    .is_write      (req_write),
    .size          (size),
    .target        (target),
    .second_beat   (second_beat),
    .two_beat_start(two_beat_start),
    .rd_final      (rd_final),
    .ide_rdata     (ide_rdata),
    .rsp_valid     (rsp_valid),
    .rsp_rdata     (rsp_rdata)
  );

  // R8 / R4 / R11: an unmapped access never reaches the core
  a_r8_no_strobe_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    accept && target == TGT_NONE |-> !ide_sel);

  // R4: unmapped byte read answers with a single all-ones byte
  a_r4_byte_fill: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !req_write && target == TGT_NONE && size == SZ_BYTE
      |=> rsp_valid && rsp_rdata == 32'h0000_00FF);

  // R5: halfword data write leaves the bridge byte-reversed
  a_r5_half_swap: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_write && target == TGT_DATA && size == SZ_HALF
      |-> ide_wdata == {req_wdata[7:0], req_wdata[15:8]});

  // R9: every response traces back to a core read beat or an unmapped read
  a_r9_rsp_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(ide_sel && !ide_wr) || $past(accept && !req_write && target == TGT_NONE));

  // R9: writes never answer
  a_r9_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_write && target != TGT_DATA |=> !rsp_valid);

endmodule

// File: tb/ide_mmio_bridge_bench.sv
module ide_mmio_bridge_bench;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        host_ready, rsp_valid, ide_sel, ide_wr;
  logic [31:0] rsp_rdata;
  logic [3:0]  ide_reg;
  logic [15:0] ide_wdata, ide_rdata;

  always #(CLK_P/2) clk = ~clk;

  ide_mmio_bridge u_ide_mmio_bridge (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .host_ready(host_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ide_sel(ide_sel), .ide_wr(ide_wr), .ide_reg(ide_reg),
    .ide_wdata(ide_wdata), .ide_rdata(ide_rdata)
  );

  // core model: data port counts read beats, task registers echo their number
  logic [15:0] core_cnt = '0;
  always @(posedge clk)
    if (rst_n && ide_sel && !ide_wr && ide_reg == 4'd0) core_cnt <= core_cnt + 16'd1;
  assign ide_rdata = (ide_reg == 4'd0) ? (16'hC000 + core_cnt) : {8'h5A, ide_reg, ide_reg};

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          c;
    logic        wr;
    logic [3:0]  rg;
    logic [15:0] wd;
    logic        busy;
    string       rq;
  } strobe_t;
  typedef struct {
    int          c;
    logic [31:0] d;
    string       rq;
  } resp_t;

  strobe_t exp_s[$];
  resp_t   exp_r[$];
  int n_chk = 0;
  int n_bad = 0;
  int exp_cnt = 0;
  bit mon_on = 1'b0;

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] rev16(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction

  // driver: called just after a rising edge; queues what must follow
  task automatic issue(input bit wr, input logic [1:0] sz, input logic [31:0] a,
                       input logic [31:0] wd, input string rq);
    int   idx;
    int   t;
    bit   word_data;
    logic [15:0] d0, d1;
    idx = int'(a[11:4]);
    t   = cyc;
    word_data = 1'b0;
    if (sz == 2'd0 && idx >= 1 && idx <= 7) begin
      exp_s.push_back('{t, wr, 4'(idx), {8'h00, wd[7:0]}, 1'b0, rq});
      if (!wr) exp_r.push_back('{t + 1, {24'h0, 4'(idx), 4'(idx)}, rq});
    end else if (sz == 2'd0 && (idx == 8 || idx == 22)) begin
      exp_s.push_back('{t, wr, 4'd8, {8'h00, wd[7:0]}, 1'b0, rq});
      if (!wr) exp_r.push_back('{t + 1, 32'h0000_0088, rq});
    end else if (sz == 2'd1 && idx == 0) begin
      exp_s.push_back('{t, wr, 4'd0, rev16(wd[15:0]), 1'b0, rq});
      if (!wr) begin
        d0 = 16'hC000 + 16'(exp_cnt);
        exp_cnt++;
        exp_r.push_back('{t + 1, {16'h0, rev16(d0)}, rq});
      end
    end else if (sz == 2'd2 && idx == 0) begin
      word_data = 1'b1;
      exp_s.push_back('{t,     wr, 4'd0, {wd[23:16], wd[31:24]}, 1'b0, rq});
      exp_s.push_back('{t + 1, wr, 4'd0, {wd[7:0],   wd[15:8]},  1'b1, rq});
      if (!wr) begin
        d0 = 16'hC000 + 16'(exp_cnt);
        d1 = 16'hC000 + 16'(exp_cnt + 1);
        exp_cnt += 2;
        exp_r.push_back('{t + 2, {d0[7:0], d0[15:8], d1[7:0], d1[15:8]}, rq});
      end
    end else if (!wr) begin
      exp_r.push_back('{t + 1, (sz == 2'd0) ? 32'h0000_00FF :
                               (sz == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF, rq});
    end
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (word_data) begin
      @(posedge clk); #1;
    end
  endtask

  // monitor: samples mid-cycle
  always @(negedge clk) begin
    if (mon_on) begin
      if (ide_sel) begin
        if (exp_s.size() == 0) begin
          check(1'b0, "R4/R8/R11 unexpected core strobe", {28'h0, ide_reg}, 32'h0);
        end else begin
          strobe_t e;
          e = exp_s.pop_front();
          check(e.c == cyc && e.wr == ide_wr && e.rg == ide_reg &&
                (!e.wr || e.wd == ide_wdata) && host_ready == !e.busy,
                e.rq, {cyc[11:0], ide_wr, host_ready, ide_reg, ide_wdata},
                {e.c[11:0], e.wr, !e.busy, e.rg, e.wr ? e.wd : ide_wdata});
        end
      end
      if (rsp_valid) begin
        if (exp_r.size() == 0) begin
          check(1'b0, "R9 unexpected response", rsp_rdata, 32'h0);
        end else begin
          resp_t r;
          r = exp_r.pop_front();
          check(r.c == cyc && r.d == rsp_rdata, r.rq, rsp_rdata, r.d);
          if (r.c != cyc) $display("    (R9 timing: cycle %0d expected %0d)", cyc, r.c);
        end
      end
    end
  end

  bit done = 1'b0;
  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      check(1'b0, "watchdog expired", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state while held
    check(!rsp_valid && !ide_sel && host_ready, "R10 reset state",
          {29'h0, rsp_valid, ide_sel, host_ready}, 32'h1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(!rsp_valid && !ide_sel && host_ready, "R10 after release",
          {29'h0, rsp_valid, ide_sel, host_ready}, 32'h1);
    mon_on = 1'b1;
    @(posedge clk); #1;

    // R2: task-file writes and reads
    issue(1'b1, 2'd0, 32'h0000_0030, 32'hDEAD_BEA7, "R2 byte write idx3");
    for (int i = 1; i <= 7; i++)
      issue(1'b0, 2'd0, 32'(i) << 4, 32'h0, "R2 byte read task file");
    // R3: both control aliases
    issue(1'b1, 2'd0, 32'h0000_0080, 32'h0000_0004, "R3 ctrl write idx8");
    issue(1'b1, 2'd0, 32'h0000_0160, 32'h0000_0002, "R3 ctrl write idx22");
    issue(1'b0, 2'd0, 32'h0000_0087, 32'h0, "R3 alt status read idx8");
    issue(1'b0, 2'd0, 32'h0000_016C, 32'h0, "R3 alt status read idx22");
    // R1: upper and low address bits ignored
    issue(1'b0, 2'd0, 32'hABCD_5035, 32'h0, "R1 aliased read idx3");
    issue(1'b1, 2'd0, 32'h8000_F05F, 32'h0000_0011, "R1 aliased write idx5");
    // R4: unmapped bytes
    issue(1'b0, 2'd0, 32'h0000_0090, 32'h0, "R4 byte read idx9");
    issue(1'b1, 2'd0, 32'h0000_0090, 32'h0000_00AA, "R4 byte write idx9");
    issue(1'b0, 2'd0, 32'h0000_0000, 32'h0, "R4 byte read idx0");
    issue(1'b1, 2'd0, 32'h0000_0FF0, 32'h0000_0055, "R4 byte write idx255");
    // R5: halfword data port
    issue(1'b1, 2'd1, 32'h0000_0000, 32'h0000_1234, "R5 half write");
    issue(1'b0, 2'd1, 32'h0000_0002, 32'h0, "R5 half read");
    // R6 / R7: word data port
    issue(1'b1, 2'd2, 32'h0000_0000, 32'h1122_3344, "R6 word write");
    issue(1'b0, 2'd2, 32'h0000_0000, 32'h0, "R7 word read");
    issue(1'b0, 2'd1, 32'h0000_0000, 32'h0, "R5 half read after word");
    issue(1'b0, 2'd2, 32'h1000_0000, 32'h0, "R7 word read aliased");
    // R8: wide accesses off the data port
    issue(1'b0, 2'd1, 32'h0000_0010, 32'h0, "R8 half read idx1");
    issue(1'b0, 2'd2, 32'h0000_0080, 32'h0, "R8 word read idx8");
    issue(1'b1, 2'd1, 32'h0000_0020, 32'h0000_BEEF, "R8 half write idx2");
    issue(1'b1, 2'd2, 32'h0000_0160, 32'hCAFE_F00D, "R8 word write idx22");
    // R11: reserved size
    issue(1'b0, 2'd3, 32'h0000_0000, 32'h0, "R11 reserved read");
    issue(1'b1, 2'd3, 32'h0000_0010, 32'h0000_0099, "R11 reserved write");
    issue(1'b0, 2'd0, 32'h0000_0010, 32'h0, "R2 read after reserved");

    repeat (4) @(posedge clk);
    @(negedge clk);
    check(exp_s.size() == 0, "R6 all core beats seen", 32'(exp_s.size()), 32'h0);
    check(exp_r.size() == 0, "R9 all responses seen", 32'(exp_r.size()), 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule